// File: doc/BRIEF.md
# Fault-Tolerant Extra-Stage Cube Switch Fabric

This block moves one permutation of packets per clock from N = 2^n input ports to N output ports. It does so through n + f stages of 2x2 exchange switches. Stage k pairs lines whose labels differ only in bit (k mod n), so the stage masks run through the unit vectors over and over. Every window of n consecutive stages then covers all address bits. Each switch has a demultiplexer/multiplexer bypass. A switch marked faulty can only pass its two lines straight through and never exchanges them.

A fault map with one bit per switch is written through a small write port, normally while no traffic flows. Each cycle, a combinational route setup finds a path for each valid packet. For every stage, the path chooses straight or exchange, reaches the packet's destination tag, and never needs an exchange at a faulty switch. Because there are f extra stages, a packet whose switch is faulty can step onto a neighbouring line and correct that detour later. Any fault set of up to f switches therefore keeps every destination reachable.

The data leaves through one output register. Three flags, registered alongside the data, report the following:
- two valid packets targeting one port,
- more than f faults marked,
- a valid packet with no fault-free path.

Top module: `ft_cube_net`

## Requirements
- R1: A fault bit is written when `flt_we` is high at a clock edge. The address is stage*(N/2) + switch, and `flt_set` is the value written. The switch number of line x in stage k is x with bit (k mod n) deleted, the bits above it shifted down by one. Addresses at or above (n+f)*N/2 are ignored. Reset clears all fault bits.
- R2: Destination tags are n bits per port, port i at bits [i*n +: n]. With at most f faults marked, every valid packet appears on output port equal to its tag one clock later, with its data unchanged.
- R3: A faulty switch never exchanges. When no path to a valid packet's destination avoids exchanging at a faulty switch, that packet is dropped and `err_noroute` is high in the cycle its data would have appeared.
- R4: An output port with no packet routed to it has its valid bit low in the same cycle.
- R5: If two or more valid packets carry the same tag, the lowest-numbered input port wins that output and `err_conflict` is high one clock later.
- R6: `err_faults` is high one clock after any cycle in which more than f fault bits are set, and low otherwise.
- R7: While reset is held and in the first cycle after it, all output valids and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_we | input | 1 | Fault map write strobe |
| flt_addr | input | $clog2((n+f)*N/2) | Fault map bit address (stage*(N/2)+switch) |
| flt_set | input | 1 | Value written: 1 = faulty |
| in_valid | input | N | Per-port packet valid |
| in_dst | input | N*n | Per-port destination tags |
| in_data | input | N*W | Per-port payloads |
| out_valid | output | N | Per-port output valid (registered) |
| out_data | output | N*W | Per-port output payloads (registered) |
| err_conflict | output | 1 | Two valid packets shared a destination |
| err_faults | output | 1 | More than f switches marked faulty |
| err_noroute | output | 1 | A valid packet had no fault-free path |

## Verification
A corrupted fault map, a wrong switch numbering or a broken path search shows up as a missing or misplaced payload on the output ports. It can also show up as a spurious `err_noroute`, and either way it is visible exactly one clock after the permutation is applied. The fault sets used place faults on the stage that alone handles the top address bit. That forces detours through the extra stages, so an error in the detour logic is exposed at once rather than only under rare traffic. A fault map that fails to load or clear shows up on `err_faults` one clock after the write.

// File: rtl/ft_cube_net.sv
module ft_cube_net #(
  parameter int N_BITS   = 3,
  parameter int N_FAULTS = 2,
  parameter int DATA_W   = 8,
  localparam int N      = 1 << N_BITS,
  localparam int STAGES = N_BITS + N_FAULTS,
  localparam int HALF   = N / 2,
  localparam int FBITS  = STAGES * HALF,
  localparam int FA_W   = $clog2(FBITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flt_we,
  input  logic [FA_W-1:0]      flt_addr,
  input  logic                 flt_set,
  input  logic [N-1:0]         in_valid,
  input  logic [N*N_BITS-1:0]  in_dst,
  input  logic [N*DATA_W-1:0]  in_data,
  output logic [N-1:0]         out_valid,
  output logic [N*DATA_W-1:0]  out_data,
  output logic                 err_conflict,
  output logic                 err_faults,
  output logic                 err_noroute
);
  localparam int PATS = 1 << STAGES;
  localparam int SW_W = (N_BITS > 1) ? N_BITS - 1 : 1;

  logic [FBITS-1:0]  fault_q;
  logic [N-1:0]      found;
  logic [N_BITS-1:0] land [N];
  logic [N-1:0]      nxt_valid;
  logic [N*DATA_W-1:0] nxt_data;
  logic              conflict;

  function automatic logic [SW_W-1:0] sw_of(input logic [N_BITS-1:0] line, input int b);
    logic [N_BITS-1:0] hi, lo;
    hi = line >> (b + 1);
    lo = line & N_BITS'((1 << b) - 1);
    return SW_W'((hi << b) | lo);
  endfunction

  always_comb begin
    logic [N_BITS-1:0] x;
    logic ok;
    for (int i = 0; i < N; i++) begin
      found[i] = 1'b0;
      land[i]  = N_BITS'(i);
      for (int p = 0; p < PATS; p++) begin
        x  = N_BITS'(i);
        ok = 1'b1;
        for (int k = 0; k < STAGES; k++) begin
          if (p[k]) begin
            if (fault_q[FA_W'(k * HALF) + FA_W'(sw_of(x, k % N_BITS))]) ok = 1'b0;
            x = x ^ N_BITS'(1 << (k % N_BITS));
          end
        end
        if (!found[i] && ok && x == in_dst[i*N_BITS +: N_BITS]) begin
          found[i] = 1'b1;
          land[i]  = x;
        end
      end
    end
  end

  always_comb begin
    nxt_valid = '0;
    nxt_data  = '0;
    for (int j = 0; j < N; j++)
      for (int i = N - 1; i >= 0; i--)
        if (in_valid[i] && found[i] && land[i] == N_BITS'(j)) begin
          nxt_valid[j] = 1'b1;
          nxt_data[j*DATA_W +: DATA_W] = in_data[i*DATA_W +: DATA_W];
        end
  end

  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (in_valid[i] && in_valid[j] &&
            in_dst[i*N_BITS +: N_BITS] == in_dst[j*N_BITS +: N_BITS])
          conflict = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q      <= '0;
      out_valid    <= '0;
      out_data     <= '0;
      err_conflict <= 1'b0;
      err_faults   <= 1'b0;
      err_noroute  <= 1'b0;
    end else begin
      if (flt_we && {1'b0, flt_addr} < (FA_W + 1)'(FBITS)) fault_q[flt_addr] <= flt_set;
      out_valid    <= nxt_valid;
      out_data     <= nxt_data;
      err_conflict <= conflict;
      err_faults   <= $countones(fault_q) > N_FAULTS;
      err_noroute  <= |(in_valid & ~found);
    end
  end
endmodule

// File: rtl/ft_cube_net_chk.sv
module ft_cube_net_chk #(
  parameter int N_BITS   = 3,
  parameter int N_FAULTS = 2,
  localparam int N      = 1 << N_BITS,
  localparam int FBITS  = (N_BITS + N_FAULTS) * (N / 2),
  localparam int FA_W   = $clog2(FBITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_we,
  input logic [FA_W-1:0]  flt_addr,
  input logic             flt_set,
  input logic [FBITS-1:0] fault_q,
  input logic [N-1:0]     in_valid,
  input logic [N-1:0]     out_valid,
  input logic             err_conflict,
  input logic             err_faults,
  input logic             err_noroute
);
  AST_FAULT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_we && ({1'b0, flt_addr} < (FA_W + 1)'(FBITS)) |=> fault_q[$past(flt_addr)] == $past(flt_set)); // R1

  AST_ROUTE_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fault_q) <= N_FAULTS) |=> !err_noroute); // R2

  AST_OUT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $countones(out_valid) <= $countones($past(in_valid))); // R4

  AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_conflict |-> $countones(out_valid) < $countones($past(in_valid))); // R5

  AST_FAULT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fault_q) > N_FAULTS) |=> err_faults); // R6
endmodule

bind ft_cube_net ft_cube_net_chk #(.N_BITS(N_BITS), .N_FAULTS(N_FAULTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_we(flt_we), .flt_addr(flt_addr), .flt_set(flt_set),
  .fault_q(fault_q), .in_valid(in_valid), .out_valid(out_valid),
  .err_conflict(err_conflict), .err_faults(err_faults), .err_noroute(err_noroute)
);

// File: tb/ft_cube_net_tb.sv
module ft_cube_net_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int NF = 2;
  localparam int W  = 8;
  localparam int N  = 1 << NB;
  localparam int FB = (NB + NF) * (N / 2);
  localparam int AW = $clog2(FB);

  // {fault map[19:0], tags (port i at [3i+:3]) [23:0], valid[7:0]}
  localparam logic [51:0] VEC [8] = '{
    {20'h00000, 24'hFAC688, 8'hFF},
    {20'h00100, 24'h053977, 8'hFF},
    {20'h00300, 24'h4C1DE5, 8'hFF},
    {20'h00401, 24'h1F58D1, 8'hFF},
    {20'h81000, 24'h053977, 8'hFF},
    {20'h00060, 24'h1F58D1, 8'h0F},
    {20'h00011, 24'h4C1DE5, 8'hA5},
    {20'h00300, 24'hFAC688, 8'h3C}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic flt_we = 1'b0, flt_set = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [N-1:0] in_valid = '0;
  logic [N*NB-1:0] in_dst = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0] out_valid;
  logic [N*W-1:0] out_data;
  logic err_conflict, err_faults, err_noroute;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ft_cube_net #(.N_BITS(NB), .N_FAULTS(NF), .DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flt_we(flt_we), .flt_addr(flt_addr), .flt_set(flt_set),
    .in_valid(in_valid), .in_dst(in_dst), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .err_conflict(err_conflict), .err_faults(err_faults), .err_noroute(err_noroute)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input bit v);
    @(negedge clk);
    flt_we = 1'b1; flt_addr = AW'(a); flt_set = v;
    @(negedge clk);
    flt_we = 1'b0;
  endtask

  task automatic load_map(input logic [FB-1:0] m);
    for (int a = 0; a < FB; a++) wr(a, m[a]);
  endtask

  // Apply one cycle of traffic; check outputs one clock later.
  task automatic apply(input logic [N-1:0] v, input logic [N*NB-1:0] d, input string req);
    logic [N-1:0] ev;
    logic [N*W-1:0] ed;
    ev = '0; ed = '0;
    @(negedge clk);
    in_valid = v; in_dst = d;
    for (int i = 0; i < N; i++) in_data[i*W +: W] = W'($urandom);
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) begin
        ev[d[i*NB +: NB]] = 1'b1;
        ed[d[i*NB +: NB]*W +: W] = in_data[i*W +: W];
      end
    @(negedge clk);
    in_valid = '0;
    chk(out_valid == ev, {req, " R4 valids"}, int'(out_valid), int'(ev));
    for (int j = 0; j < N; j++)
      if (ev[j]) chk(out_data[j*W +: W] == ed[j*W +: W], {req, " R2 data"},
                     int'(out_data[j*W +: W]), int'(ed[j*W +: W]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == '0 && !err_conflict && !err_faults && !err_noroute, "R7 in reset",
        int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0 && !err_conflict && !err_faults && !err_noroute, "R7 after reset",
        int'(out_valid), 0);

    for (int e = 0; e < 8; e++) begin
      load_map(VEC[e][51:32]);
      apply(VEC[e][7:0], VEC[e][31:8], "R2 table");
      chk(!err_noroute && !err_conflict, "R2 table flags", int'(err_noroute), 0);
    end

    for (int r = 0; r < 150; r++) begin
      logic [NB-1:0] perm [N];
      logic [N*NB-1:0] d;
      logic [FB-1:0] m;
      for (int i = 0; i < N; i++) perm[i] = NB'(i);
      for (int i = N - 1; i > 0; i--) begin
        int j;
        logic [NB-1:0] t;
        j = int'($urandom % (i + 1));
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      for (int i = 0; i < N; i++) d[i*NB +: NB] = perm[i];
      m = '0;
      for (int k = 0; k < int'($urandom % (NF + 1)); k++) m[$urandom % FB] = 1'b1;
      load_map(m);
      apply(N'($urandom), d, "R2 random");
      chk(!err_noroute && !err_faults, "R2 random flags", int'(err_noroute), 0);
    end

    // R5: ports 2 and 5 both target 3; port 2 must win
    load_map('0);
    begin
      logic [N*NB-1:0] d;
      d = '0; d[2*NB +: NB] = 3'd3; d[5*NB +: NB] = 3'd3;
      @(negedge clk);
      in_valid = 8'h24; in_dst = d;
      in_data = '0; in_data[2*W +: W] = 8'h5A; in_data[5*W +: W] = 8'hC3;
      @(negedge clk);
      in_valid = '0;
      chk(out_valid == 8'h08, "R5 one winner", int'(out_valid), 8);
      chk(out_data[3*W +: W] == 8'h5A, "R5 lowest port wins", int'(out_data[3*W +: W]), 8'h5A);
      chk(err_conflict, "R5 conflict flag", int'(err_conflict), 1);
    end

    // R1: writes above the map range are ignored
    for (int a = FB; a < (1 << AW); a++) wr(a, 1'b1);
    @(negedge clk);
    chk(!err_faults, "R1 out-of-range ignored", int'(err_faults), 0);

    // R3 + R6: all stage-2 switches faulty (addr 8..11), bit 2 cannot change
    load_map(20'h00F00);
    @(negedge clk);
    chk(err_faults, "R6 over limit", int'(err_faults), 1);
    begin
      logic [N*NB-1:0] d;
      d = '0; d[0 +: NB] = 3'd4; d[NB +: NB] = 3'd1;
      @(negedge clk);
      in_valid = 8'h03; in_dst = d;
      @(negedge clk);
      in_valid = '0;
      chk(out_valid == 8'h02, "R3 blocked packet dropped", int'(out_valid), 2);
      chk(err_noroute, "R3 noroute flag", int'(err_noroute), 1);
    end

    // R6 at the limit: exactly f faults
    load_map(20'h00300);
    @(negedge clk);
    chk(!err_faults, "R6 at limit", int'(err_faults), 0);

    // R1/R7: reset clears the map
    load_map(20'h00F00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!err_faults, "R1 reset clears map", int'(err_faults), 0);
    apply(8'hFF, 24'h053977, "R2 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule